// File: doc/BRIEF.md
# Hibernate Wake and Reset Sequencer

This block runs from the slow always-on timekeeping clock. It drives the system power-enable and system reset outputs. A software write to the hibernate control register moves the block from normal running into hibernation, and the power-enable output drops. While the block hibernates it watches an active-low wake pin. A wake counts only when the pin stays low for a programmed number of slow-clock ticks. A shorter pulse is treated as a glitch, the block returns to hibernation and the count starts over.

Once a wake is accepted, power comes back at once. The system reset output is held low for a second programmed number of ticks and then released, and the block is back in normal running. Both tick counts come from registers. Only a fixed slice of each register is implemented, so each count is a multiple of 32 ticks. The wake pin must be synchronous to the slow clock when it arrives at this block.

Top module: `hib_wake_seq`

## Requirements
- R1: After reset, the block is running, `pwr_en` = 1 and `sys_rst_n` = 1, and the filter and reset-hold registers read 0.
- R2: In the running state, a write to offset 0x20 with data bit 0 = 1 requests hibernate, and `pwr_en` reads 0 after the clock edge that takes the write. A write there with bit 0 = 0 has no effect. Offset 0x20 always reads 0.
- R3: The wake filter register at offset 0x24 stores data bits [15:5] and reads back as `wdata & 0x0000FFE0`. The filter time T in ticks is that read value.
- R4: The reset-hold register at offset 0x28 stores data bits [11:5] and reads back as `wdata & 0x00000FE0`. The hold time R in ticks is that read value.
- R5: Any other offset reads 0. A write to another offset changes no register and no output.
- R6: While hibernating, `pwr_en` stays 0 and `sys_rst_n` stays 1 for as long as `wake_n` is high.
- R7: A wake is accepted when `wake_n` is sampled low on T+2 consecutive rising edges, counting from the first low sample taken while hibernating. After the last of those edges `pwr_en` = 1 and `sys_rst_n` = 0.
- R8: If `wake_n` is sampled high before the wake is accepted, the block returns to hibernation with power off, and the next low pulse must again last the full T+2 edges.
- R9: After a wake, `sys_rst_n` stays low for exactly R+1 clock cycles and then goes high. The block is then running again with `pwr_en` = 1.
- R10: A hibernate request written while the block is hibernating, filtering or holding reset is ignored and does not shorten or alter the wake sequence.
- R11: `pwr_en` and `sys_rst_n` are never both low, and every rise of `pwr_en` comes with `sys_rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| wake_n | input | 1 | Active-low wake pin, synchronous to `clk` |
| pwr_en | output | 1 | System power enable, high when powered |
| sys_rst_n | output | 1 | Active-low system reset output |

## Verification
The assertions are checked on every cycle. They cover the following: the two outputs are never both low; power never returns without reset being low; a glitch during filtering always sends the block back to hibernation; an accepted hibernate write always drops power on the next edge; the unimplemented read bits are always zero. The exact lengths of the filter window and the reset hold, and the fact that a restarted filter needs the full window again, can only be shown by the bench scenarios. The same holds for hibernate writes being ignored in the middle of a wake, since those depend on programmed values and on precise timing.

// File: rtl/hib_pkg.sv
package hib_pkg;

    localparam int unsigned HIB_ADDR_W = 8;
    localparam int unsigned HIB_DATA_W = 32;

    // byte offsets that software decodes
    localparam logic [HIB_ADDR_W-1:0] OFS_HIB_CTRL = 8'h20;
    localparam logic [HIB_ADDR_W-1:0] OFS_WAKE_FLT = 8'h24;
    localparam logic [HIB_ADDR_W-1:0] OFS_RST_HOLD = 8'h28;

    // implemented slices of the two count registers
    localparam int unsigned CNT_LSB  = 5;
    localparam int unsigned FLT_MSB  = 15;
    localparam int unsigned HOLD_MSB = 11;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_FILTER = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/hib_regs.sv
module hib_regs
    import hib_pkg::*;
#(
    parameter int unsigned ADDR_W   = HIB_ADDR_W,
    parameter int unsigned DATA_W   = HIB_DATA_W,
    parameter int unsigned LSB      = CNT_LSB,
    parameter int unsigned F_MSB    = FLT_MSB,
    parameter int unsigned H_MSB    = HOLD_MSB,
    localparam int unsigned F_W     = F_MSB - LSB + 1,
    localparam int unsigned H_W     = H_MSB - LSB + 1,
    localparam int unsigned TICK_W  = F_MSB + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sleep_req,
    output logic [TICK_W-1:0] flt_ticks,
    output logic [TICK_W-1:0] hold_ticks
);

    typedef struct packed {
        logic [F_W-1:0] flt;
        logic [H_W-1:0] hold;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we && addr == OFS_WAKE_FLT) r_d.flt  = wdata[F_MSB:LSB];
        if (we && addr == OFS_RST_HOLD) r_d.hold = wdata[H_MSB:LSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sleep_req  = we && (addr == OFS_HIB_CTRL) && wdata[0];
    assign flt_ticks  = {r_q.flt, {LSB{1'b0}}};
    assign hold_ticks = {{(TICK_W-H_MSB-1){1'b0}}, r_q.hold, {LSB{1'b0}}};

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_WAKE_FLT: rdata[F_MSB:LSB] = r_q.flt;
            OFS_RST_HOLD: rdata[H_MSB:LSB] = r_q.hold;
            default:      rdata = '0;
        endcase
    end

    // R3
    flt_rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_WAKE_FLT) |-> (rdata[LSB-1:0] == '0 && rdata[DATA_W-1:F_MSB+1] == '0));
    // R4
    hold_rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_RST_HOLD) |-> (rdata[LSB-1:0] == '0 && rdata[DATA_W-1:H_MSB+1] == '0));

endmodule

// File: rtl/hib_seq.sv
module hib_seq
    import hib_pkg::*;
#(
    parameter int unsigned TICK_W = FLT_MSB + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              wake_n,
    input  logic [TICK_W-1:0] flt_ticks,
    input  logic [TICK_W-1:0] hold_ticks,
    output logic              pwr_en,
    output logic              sys_rst_n
);

    typedef struct packed {
        seq_state_e        st;
        logic [TICK_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_RUN: begin
                if (sleep_req) begin
                    s_d.st  = ST_SLEEP;
                    s_d.cnt = '0;
                end
            end
            ST_SLEEP: begin
                if (!wake_n) begin
                    s_d.st  = ST_FILTER;
                    s_d.cnt = '0;
                end
            end
            ST_FILTER: begin
                if (wake_n) begin
                    s_d.st  = ST_SLEEP;
                    s_d.cnt = '0;
                end else if (s_q.cnt >= flt_ticks) begin
                    s_d.st  = ST_HOLD;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (s_q.cnt >= hold_ticks) begin
                    s_d.st  = ST_RUN;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d = '{st: ST_RUN, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_RUN, cnt: '0};
        else        s_q <= s_d;
    end

    assign pwr_en    = !(s_q.st == ST_SLEEP || s_q.st == ST_FILTER);
    assign sys_rst_n = (s_q.st != ST_HOLD);

    // R2
    sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN && sleep_req) |=> !pwr_en);
    // R8
    glitch_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_FILTER && wake_n) |=> (s_q.st == ST_SLEEP && !pwr_en));
    // R11
    never_both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pwr_en && !sys_rst_n));
    // R11
    power_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> !sys_rst_n);
    // R9
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> (pwr_en && s_q.st == ST_RUN));

endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq
    import hib_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HIB_ADDR_W-1:0] reg_addr,
    input  logic                  reg_we,
    input  logic [HIB_DATA_W-1:0] reg_wdata,
    output logic [HIB_DATA_W-1:0] reg_rdata,
    input  logic                  wake_n,
    output logic                  pwr_en,
    output logic                  sys_rst_n
);

    localparam int unsigned TICK_W = FLT_MSB + 1;

    logic              sleep_req;
    logic [TICK_W-1:0] flt_ticks;
    logic [TICK_W-1:0] hold_ticks;

    hib_regs #(
        .ADDR_W (HIB_ADDR_W),
        .DATA_W (HIB_DATA_W),
        .LSB    (CNT_LSB),
        .F_MSB  (FLT_MSB),
        .H_MSB  (HOLD_MSB)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .we         (reg_we),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .sleep_req  (sleep_req),
        .flt_ticks  (flt_ticks),
        .hold_ticks (hold_ticks)
    );

    hib_seq #(
        .TICK_W (TICK_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .wake_n     (wake_n),
        .flt_ticks  (flt_ticks),
        .hold_ticks (hold_ticks),
        .pwr_en     (pwr_en),
        .sys_rst_n  (sys_rst_n)
    );

endmodule

// File: tb/hib_wake_seq_bench.sv
`timescale 1ns/1ps
module hib_wake_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wake_n = 1'b1;
    logic        pwr_en;
    logic        sys_rst_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hib_wake_seq u_hib_wake_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wake_n    (wake_n),
        .pwr_en    (pwr_en),
        .sys_rst_n (sys_rst_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic t_reset;
        check("R1 pwr_en", {31'd0, pwr_en}, 32'd1);
        check("R1 sys_rst_n", {31'd0, sys_rst_n}, 32'd1);
        rd_chk("R1 filter reg", 8'h24, 32'd0);
        rd_chk("R1 hold reg", 8'h28, 32'd0);
    endtask

    task automatic t_regs;
        wr(8'h24, 32'hFFFF_FFFF);
        rd_chk("R3 filter mask", 8'h24, 32'h0000_FFE0);
        wr(8'h28, 32'hFFFF_FFFF);
        rd_chk("R4 hold mask", 8'h28, 32'h0000_0FE0);
        wr(8'h20, 32'hFFFF_FFFE);
        check("R2 bit0 clear no sleep", {31'd0, pwr_en}, 32'd1);
        rd_chk("R2 ctrl reads 0", 8'h20, 32'd0);
        wr(8'h30, 32'hFFFF_FFFF);
        rd_chk("R5 unmapped reads 0", 8'h30, 32'd0);
        check("R5 unmapped no effect", {30'd0, pwr_en, sys_rst_n}, 32'd3);
        rd_chk("R5 filter untouched", 8'h24, 32'h0000_FFE0);
    endtask

    // program T and R, sleep, then wake with a clean pulse
    task automatic t_wake(input logic [31:0] fval, input logic [31:0] hval);
        int t = int'(fval & 32'hFFE0);
        int r = int'(hval & 32'h0FE0);
        wr(8'h24, fval);
        wr(8'h28, hval);
        wr(8'h20, 32'h1);
        check("R2 sleep pwr_en", {31'd0, pwr_en}, 32'd0);
        cycles(5);
        check("R6 idle sleep", {30'd0, pwr_en, sys_rst_n}, 32'd1);
        wake_n = 1'b0;
        cycles(t + 1);
        check("R7 still filtering", {30'd0, pwr_en, sys_rst_n}, 32'd1);
        cycles(1);
        check("R7 wake accepted", {30'd0, pwr_en, sys_rst_n}, 32'd2);
        wake_n = 1'b1;
        cycles(r);
        check("R9 reset still low", {30'd0, pwr_en, sys_rst_n}, 32'd2);
        cycles(1);
        check("R9 reset released", {30'd0, pwr_en, sys_rst_n}, 32'd3);
    endtask

    task automatic t_glitch;
        wr(8'h24, 32'h0000_0060);
        wr(8'h28, 32'h0000_0020);
        wr(8'h20, 32'h1);
        wake_n = 1'b0;
        cycles(40);
        wake_n = 1'b1;
        cycles(3);
        check("R8 glitch rejected", {30'd0, pwr_en, sys_rst_n}, 32'd1);
        wake_n = 1'b0;
        cycles(96 + 1);
        check("R8 full window again", {30'd0, pwr_en, sys_rst_n}, 32'd1);
        cycles(1);
        check("R8 accepted after restart", {30'd0, pwr_en, sys_rst_n}, 32'd2);
        wake_n = 1'b1;
        // R10: sleep request during reset hold is ignored
        wr(8'h20, 32'h1);
        check("R10 hold unaffected", {30'd0, pwr_en, sys_rst_n}, 32'd2);
        cycles(40);
        check("R10 back to run", {30'd0, pwr_en, sys_rst_n}, 32'd3);
    endtask

    task automatic t_sleep_rewrite;
        wr(8'h24, 32'h0000_0000);
        wr(8'h28, 32'h0000_0000);
        wr(8'h20, 32'h1);
        wr(8'h20, 32'h1);
        check("R10 rewrite while asleep", {30'd0, pwr_en, sys_rst_n}, 32'd1);
        wake_n = 1'b0;
        cycles(1);
        check("R7 T=0 filtering", {30'd0, pwr_en, sys_rst_n}, 32'd1);
        cycles(1);
        check("R7 T=0 accepted", {30'd0, pwr_en, sys_rst_n}, 32'd2);
        wake_n = 1'b1;
        cycles(1);
        check("R9 R=0 single cycle", {30'd0, pwr_en, sys_rst_n}, 32'd3);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_regs();
        t_wake(32'h0000_0020, 32'h0000_0040);
        t_wake(32'h0000_007F, 32'h0000_003F);
        t_glitch();
        t_sleep_rewrite();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule